// File: doc/BRIEF.md
# DMA Interrupt Coalescing Unit

This unit produces the interrupt line of one DMA channel from its stream of packet-completion events. The line does not have to fire on every packet. A completion counter starts at a programmable threshold and counts down once per completion. When it reaches zero, a sticky completion-pending flag is raised and the counter is reloaded.

A second, programmable delay timer limits how long a partial batch can wait. Each completion that carries a nonzero delay restarts the timer. The timer counts down on an external prescaler tick. When it runs out, a sticky delay-pending flag is raised and the completion counter starts over.

The pending flags are cleared by write-one-to-clear strobes and gated by enable bits to form the interrupt. The live counter and timer values are exposed so that a status register can return them. Register decoding, descriptor handling and data movement belong to the surrounding channel logic.

Top module: `irq_coalesce`

## Requirements
- R1: After reset, `pend_o` is 0, `irq_o` is 0, `timer_o` is 0 and `count_o` equals the RESET_THRESH parameter (default 1).
- R2: A completion pulse with no control write and no timer expiry in the same cycle decrements `count_o`. If the decremented value is zero, pending bit 0 (completion) is set and `count_o` loads `thresh_i` instead. With a threshold of 0, the first completion wraps the counter to its all-ones value without setting a flag.
- R3: A control write strobe loads `count_o` from `thresh_i` on the next edge. A completion in the same cycle is then not counted.
- R4: A completion with a nonzero `delay_i` loads `timer_o` with `delay_i`, even if the timer is already running and even if a tick arrives in the same cycle. A completion with `delay_i` of 0 leaves the timer untouched.
- R5: While `timer_o` is nonzero and not being restarted, each tick decrements it by one. It holds without a tick and stays at 0 once it is there.
- R6: A tick that takes the timer from 1 to 0 sets pending bit 1 (delay) and loads `count_o` from `thresh_i`. A completion in that cycle with a zero delay is not counted.
- R7: A 1 on bit i of `clr_i` clears pending bit i. If a set event for bit i arrives in the same cycle, the bit stays set. Without clear, pending bits stay set.
- R8: `irq_o` is high exactly when some pending bit i has `irq_en_i` bit i set, in the same cycle (default variant). The enables never change `pend_o`.
- R9: `count_o` and `timer_o` always show the live counter and timer state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| done_i | input | 1 | One-cycle packet completion pulse |
| ctrl_wr_i | input | 1 | Control register write strobe; reloads the counter |
| thresh_i | input | CNT_W | Completion threshold field |
| delay_i | input | DLY_W | Delay timeout field (0 = no restart) |
| irq_en_i | input | 2 | Interrupt enables; bit 0 completion, bit 1 delay |
| clr_i | input | 2 | Write-one-to-clear strobes for the pending bits |
| tick_i | input | 1 | Prescaler strobe for the delay timer |
| pend_o | output | 2 | Sticky pending bits; bit 0 completion, bit 1 delay |
| count_o | output | CNT_W | Live completion counter |
| timer_o | output | DLY_W | Live delay timer |
| irq_o | output | 1 | Interrupt request |

## Verification
The counter is exercised with thresholds of 3, 2 and 0. These runs distinguish a correct decrement and reload from an off-by-one or a missing wrap. The timer is driven with restarts that hit a running timer, zero-delay completions that must leave it alone, and idle ticks at zero. These show whether restart, hold and floor are each handled.

Collision cycles put two events into one edge: a write with a completion, an expiry with a completion, a restart with a tick, and a clear with a set. Each of these checks that the stated priority is the one that wins. Enable patterns on a pending flag show that gating affects only the interrupt line.

// File: rtl/irq_coalesce_pkg.sv
package irq_coalesce_pkg;
   localparam int PEND_W   = 2;
   localparam int IDX_COMP = 0;
   localparam int IDX_DLY  = 1;
   typedef logic [PEND_W-1:0] pend_t;
endpackage

// File: rtl/icu_comp_counter.sv
module icu_comp_counter #(
   parameter int CNT_W   = 8,
   parameter int RST_VAL = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             done_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] thresh_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             hit_o
);
   localparam logic [CNT_W-1:0] RST_CNT = CNT_W'(RST_VAL);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] dec;

   assign dec   = cnt_q - 1'b1;
   assign hit_o = done_i && !load_i && (dec == '0);
   assign cnt_o = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= RST_CNT;
      else if (load_i || hit_o)
         cnt_q <= thresh_i;
      else if (done_i)
         cnt_q <= dec;
   end

   AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> cnt_o == $past(thresh_i)); // R3
   AST_CNT_HIT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |=> cnt_o == $past(thresh_i)); // R2
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && !load_i && !hit_o) |=> cnt_o == $past(cnt_o) - 1'b1); // R2
   AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!done_i && !load_i) |=> $stable(cnt_o)); // R9
endmodule

// File: rtl/icu_delay_timer.sv
module icu_delay_timer #(
   parameter int DLY_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             done_i,
   input  logic [DLY_W-1:0] delay_i,
   input  logic             tick_i,
   output logic [DLY_W-1:0] tmr_o,
   output logic             expire_o
);
   localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

   logic [DLY_W-1:0] tmr_q;
   logic             restart;

   assign restart  = done_i && (delay_i != '0);
   assign expire_o = tick_i && !restart && (tmr_q == ONE);
   assign tmr_o    = tmr_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         tmr_q <= '0;
      else if (restart)
         tmr_q <= delay_i;
      else if (tick_i && (tmr_q != '0))
         tmr_q <= tmr_q - 1'b1;
   end

   AST_TMR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && delay_i != '0) |=> tmr_o == $past(delay_i)); // R4
   AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!done_i && !tick_i) |=> $stable(tmr_o)); // R5
   AST_TMR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_o == '0 && !done_i) |=> tmr_o == '0); // R5
   AST_TMR_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
      expire_o |=> tmr_o == '0); // R6
endmodule

// File: rtl/icu_pending.sv
module icu_pending
   import irq_coalesce_pkg::*;
#(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic  clk,
   input  logic  rst_n,
   input  pend_t set_i,
   input  pend_t clr_i,
   input  pend_t ena_i,
   output pend_t pend_o,
   output logic  irq_o
);
   pend_t pend_q;

   for (genvar i = 0; i < PEND_W; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)
            pend_q[i] <= 1'b0;
         else
            pend_q[i] <= (pend_q[i] && !clr_i[i]) || set_i[i];
      end

      AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[i] |=> pend_o[i]); // R7
      AST_PEND_CLR: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[i] && !set_i[i]) |=> !pend_o[i]); // R7
      AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr_i[i] && !set_i[i]) |=> $stable(pend_o[i])); // R7
   end

   assign pend_o = pend_q;

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            irq_q <= 1'b0;
         else
            irq_q <= |(pend_q & ena_i);
      end
      assign irq_o = irq_q;
      AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         ((pend_o & ena_i) == '0) |=> !irq_o); // R8
   end else begin : g_irq_comb
      assign irq_o = |(pend_q & ena_i);
      AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         ((pend_o & ena_i) == '0) |-> !irq_o); // R8
   end
endmodule

// File: rtl/irq_coalesce.sv
module irq_coalesce
   import irq_coalesce_pkg::*;
#(
   parameter int CNT_W        = 8,
   parameter int DLY_W        = 8,
   parameter int RESET_THRESH = 1,
   parameter bit IRQ_REG      = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             done_i,
   input  logic             ctrl_wr_i,
   input  logic [CNT_W-1:0] thresh_i,
   input  logic [DLY_W-1:0] delay_i,
   input  logic [1:0]       irq_en_i,
   input  logic [1:0]       clr_i,
   input  logic             tick_i,
   output logic [1:0]       pend_o,
   output logic [CNT_W-1:0] count_o,
   output logic [DLY_W-1:0] timer_o,
   output logic             irq_o
);
   localparam longint CNT_SPAN = longint'(1) << CNT_W;

   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt_w
      $error("irq_coalesce: CNT_W out of range");
   end
   if (DLY_W < 1 || DLY_W > 16) begin : g_bad_dly_w
      $error("irq_coalesce: DLY_W out of range");
   end
   if (RESET_THRESH < 0 || longint'(RESET_THRESH) >= CNT_SPAN) begin : g_bad_rst
      $error("irq_coalesce: RESET_THRESH does not fit CNT_W");
   end

   logic  hit;
   logic  expire;
   pend_t set_vec;
   pend_t pend;

   icu_comp_counter #(.CNT_W(CNT_W), .RST_VAL(RESET_THRESH)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .done_i   (done_i),
      .load_i   (ctrl_wr_i || expire),
      .thresh_i (thresh_i),
      .cnt_o    (count_o),
      .hit_o    (hit)
   );

   icu_delay_timer #(.DLY_W(DLY_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .done_i   (done_i),
      .delay_i  (delay_i),
      .tick_i   (tick_i),
      .tmr_o    (timer_o),
      .expire_o (expire)
   );

   always_comb begin
      set_vec           = '0;
      set_vec[IDX_COMP] = hit;
      set_vec[IDX_DLY]  = expire;
   end

   icu_pending #(.IRQ_REG(IRQ_REG)) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_vec),
      .clr_i  (clr_i),
      .ena_i  (irq_en_i),
      .pend_o (pend),
      .irq_o  (irq_o)
   );

   assign pend_o = pend;

   AST_EXPIRE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> (pend_o[IDX_DLY] && count_o == $past(thresh_i))); // R6
   AST_NO_HIT_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
      !(expire && hit)); // R6
endmodule

// File: tb/test_irq_coalesce.sv
`timescale 1ns/1ps
module test_irq_coalesce;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       done_i = 1'b0, ctrl_wr_i = 1'b0, tick_i = 1'b0;
   logic [7:0] thresh_i = '0, delay_i = '0;
   logic [1:0] irq_en_i = 2'b11, clr_i = '0;
   logic [1:0] pend_o;
   logic [7:0] count_o, timer_o;
   logic       irq_o;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   irq_coalesce i_irq_coalesce (
      .clk(clk), .rst_n(rst_n), .done_i(done_i), .ctrl_wr_i(ctrl_wr_i),
      .thresh_i(thresh_i), .delay_i(delay_i), .irq_en_i(irq_en_i),
      .clr_i(clr_i), .tick_i(tick_i), .pend_o(pend_o), .count_o(count_o),
      .timer_o(timer_o), .irq_o(irq_o)
   );

   typedef struct packed {
      logic       d;
      logic       w;
      logic       t;
      logic [1:0] clr;
      logic [7:0] thr;
      logic [7:0] dly;
      logic [7:0] ecnt;
      logic [7:0] etmr;
      logic [1:0] epend;
   } vec_t;

   localparam int NV = 32;
   localparam vec_t VEC [NV] = '{
      '{1'b0,1'b1,1'b0,2'b00,8'd3,8'd0,8'd3,8'd0,2'b00},
      '{1'b1,1'b0,1'b0,2'b00,8'd3,8'd0,8'd2,8'd0,2'b00},
      '{1'b1,1'b0,1'b0,2'b00,8'd3,8'd0,8'd1,8'd0,2'b00},
      '{1'b1,1'b0,1'b0,2'b00,8'd3,8'd0,8'd3,8'd0,2'b01},
      '{1'b0,1'b0,1'b0,2'b01,8'd3,8'd0,8'd3,8'd0,2'b00},
      '{1'b1,1'b0,1'b0,2'b00,8'd3,8'd5,8'd2,8'd5,2'b00},
      '{1'b0,1'b0,1'b1,2'b00,8'd3,8'd5,8'd2,8'd4,2'b00},
      '{1'b0,1'b0,1'b1,2'b00,8'd3,8'd5,8'd2,8'd3,2'b00},
      '{1'b1,1'b0,1'b0,2'b00,8'd3,8'd5,8'd1,8'd5,2'b00},
      '{1'b0,1'b0,1'b1,2'b00,8'd3,8'd5,8'd1,8'd4,2'b00},
      '{1'b0,1'b0,1'b1,2'b00,8'd3,8'd5,8'd1,8'd3,2'b00},
      '{1'b0,1'b0,1'b1,2'b00,8'd3,8'd5,8'd1,8'd2,2'b00},
      '{1'b0,1'b0,1'b1,2'b00,8'd3,8'd5,8'd1,8'd1,2'b00},
      '{1'b0,1'b0,1'b1,2'b00,8'd3,8'd5,8'd3,8'd0,2'b10},
      '{1'b0,1'b0,1'b1,2'b00,8'd3,8'd5,8'd3,8'd0,2'b10},
      '{1'b1,1'b0,1'b0,2'b10,8'd3,8'd0,8'd2,8'd0,2'b00},
      '{1'b1,1'b0,1'b0,2'b00,8'd3,8'd2,8'd1,8'd2,2'b00},
      '{1'b0,1'b0,1'b1,2'b00,8'd3,8'd2,8'd1,8'd1,2'b00},
      '{1'b1,1'b0,1'b1,2'b00,8'd3,8'd0,8'd3,8'd0,2'b10},
      '{1'b1,1'b0,1'b0,2'b00,8'd3,8'd0,8'd2,8'd0,2'b10},
      '{1'b1,1'b1,1'b0,2'b00,8'd2,8'd0,8'd2,8'd0,2'b10},
      '{1'b1,1'b0,1'b0,2'b00,8'd2,8'd0,8'd1,8'd0,2'b10},
      '{1'b1,1'b0,1'b0,2'b01,8'd2,8'd0,8'd2,8'd0,2'b11},
      '{1'b0,1'b1,1'b0,2'b00,8'd0,8'd0,8'd0,8'd0,2'b11},
      '{1'b1,1'b0,1'b0,2'b00,8'd0,8'd0,8'd255,8'd0,2'b11},
      '{1'b0,1'b0,1'b0,2'b11,8'd0,8'd0,8'd255,8'd0,2'b00},
      '{1'b1,1'b0,1'b0,2'b00,8'd0,8'd3,8'd254,8'd3,2'b00},
      '{1'b1,1'b0,1'b1,2'b00,8'd0,8'd3,8'd253,8'd3,2'b00},
      '{1'b0,1'b0,1'b1,2'b00,8'd0,8'd3,8'd253,8'd2,2'b00},
      '{1'b1,1'b0,1'b0,2'b00,8'd0,8'd0,8'd252,8'd2,2'b00},
      '{1'b0,1'b0,1'b1,2'b00,8'd0,8'd0,8'd252,8'd1,2'b00},
      '{1'b0,1'b0,1'b1,2'b00,8'd0,8'd0,8'd0,8'd0,2'b10}
   };
   localparam string TAG [NV] = '{
      "R3","R2","R2","R2","R7","R4","R5","R5","R4","R9","R5","R5","R5","R6","R5","R4",
      "R4","R5","R6","R2","R3","R2","R7","R3","R2","R7","R4","R4","R5","R4","R5","R6"
   };

   task automatic check(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic idle_inputs();
      done_i = 1'b0; ctrl_wr_i = 1'b0; tick_i = 1'b0; clr_i = '0;
   endtask

   initial begin
      #1_000_000;
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1", "pend", pend_o, 0);
      check("R1", "count", count_o, 1);
      check("R1", "timer", timer_o, 0);
      check("R1", "irq", irq_o, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk, enables fixed at 2'b11
      for (int k = 0; k < NV; k++) begin
         done_i = VEC[k].d; ctrl_wr_i = VEC[k].w; tick_i = VEC[k].t;
         clr_i = VEC[k].clr; thresh_i = VEC[k].thr; delay_i = VEC[k].dly;
         @(negedge clk);
         check(TAG[k], "count", count_o, VEC[k].ecnt);
         check(TAG[k], "timer", timer_o, VEC[k].etmr);
         check(TAG[k], "pend", pend_o, VEC[k].epend);
         check("R8", "irq", irq_o, int'(|VEC[k].epend));
      end
      idle_inputs();

      // R8: gating of the delay flag (pend = 2'b10)
      irq_en_i = 2'b00; #1;
      check("R8", "irq en=00", irq_o, 0);
      @(negedge clk);
      check("R8", "pend kept en=00", pend_o, 2);
      irq_en_i = 2'b01; #1;
      check("R8", "irq en=01", irq_o, 0);
      irq_en_i = 2'b10; #1;
      check("R8", "irq en=10", irq_o, 1);

      // R8: gating of the completion flag (threshold 1)
      clr_i = 2'b10; thresh_i = 8'd1; ctrl_wr_i = 1'b1;
      @(negedge clk);
      idle_inputs();
      done_i = 1'b1;
      @(negedge clk);
      idle_inputs();
      check("R2", "pend thr=1", pend_o, 1);
      check("R8", "irq comp en=10", irq_o, 0);
      irq_en_i = 2'b01; #1;
      check("R8", "irq comp en=01", irq_o, 1);

      // R1: reset in mid-run
      done_i = 1'b1; delay_i = 8'd7;
      @(negedge clk);
      idle_inputs();
      rst_n = 1'b0;
      @(negedge clk);
      check("R1", "pend after reset", pend_o, 0);
      check("R1", "count after reset", count_o, 1);
      check("R1", "timer after reset", timer_o, 0);
      check("R1", "irq after reset", irq_o, 0);
      rst_n = 1'b1;

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule